// File: doc/BRIEF.md
# Piecewise-Linear Significand Function Unit

This block approximates one of three functions of an unsigned fixed-point significand x in [0.5, 1): the reciprocal, the square root or the inverse square root. The range is split into equal subintervals. The input bits just below the leading one select a subinterval, and the bits below those form the offset y of x inside that subinterval. Each function has its own coefficient bank with one packed word per subinterval. The word holds the magnitudes of an intercept a and a slope b. The unit computes a ± b·y in one multiply-add step. The step is sized so that the slope fits a 17-bit multiplier port and the untruncated offset fits a 24-bit port. The aligned sum has no more than 48 bits.

Software fills the banks through a write port before use. A caller then presents valid-qualified significands with a function code. Two cycles later a valid-qualified 24-bit result appears, in Q1.23 format. Reciprocal and inverse square root land in [1, 2) as computed. The square root value is doubled, a one-bit left shift, so that it lands in the same range.

Top module: `pwl_func_unit`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after a cycle in which `in_valid` was high, and low otherwise; reset clears both valid stages.
- R2: For an `IN_W`-bit significand whose MSB (weight 2^-1) is 1, the next `ADDR_W` bits form the bank address. The remaining low bits form the offset y, whose LSB has weight 2^-IN_W.
- R3: A coefficient word is 36 bits. Bits [35:13] hold |a| in Q1.22 and bits [12:0] hold |b| in Q2.11.
- R4: Function code 2'b00 (reciprocal) produces floor((a − b·y)·2^23).
- R5: Function code 2'b01 (square root) produces floor(2·(a + b·y)·2^23), the doubled value.
- R6: Function code 2'b10 (inverse square root) produces floor((a − b·y)·2^23).
- R7: When b·y exceeds a in a subtracting function, the result is 0.
- R8: When the scaled value reaches 2.0 or more, the result saturates to 24'hFFFFFF.
- R9: Function code 2'b11 still produces a valid output, and its result is 0.
- R10: A write to bank 3 changes no stored coefficient. A write to one bank changes only the addressed word of that bank.
- R11: `out_result` holds its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input significand is valid |
| in_func | input | 2 | Function code: 00 reciprocal, 01 square root, 10 inverse square root, 11 none |
| in_sig | input | IN_W | Input significand, MSB weight 2^-1 |
| wr_en | input | 1 | Coefficient write strobe |
| wr_bank | input | 2 | Bank to write (same codes as in_func; 3 writes nothing) |
| wr_addr | input | ADDR_W | Word address within the bank |
| wr_data | input | 36 | Packed coefficient word |
| out_valid | output | 1 | Result is valid |
| out_result | output | 24 | Result significand, Q1.23 |

## Verification
A wrong bank or address field in the first stage shows up at once as a wrong result on the very next valid output, because each subinterval is given distinct coefficients. A wrong add/subtract choice, doubling shift, clamp or saturation has the same effect for the function and offsets it touches. A lost or extra valid stage shows up within two cycles as a misaligned `out_valid`. An exhaustive sweep of every significand under every function code, in a narrow configuration, exposes such faults on the first affected input.

// File: rtl/pwl_func_pkg.sv
package pwl_func_pkg;
  typedef enum logic [1:0] {
    FN_RECIP = 2'b00,
    FN_SQRT  = 2'b01,
    FN_RSQRT = 2'b10,
    FN_NONE  = 2'b11
  } fn_e;

  localparam int WORD_W = 36;
  localparam int A_W    = 23;
  localparam int A_FRAC = 22;
  localparam int B_W    = 13;
  localparam int B_FRAC = 11;
  localparam int RES_W  = 24;
  localparam int N_BANK = 3;
endpackage

// File: rtl/pwl_coef_store.sv
module pwl_coef_store
  import pwl_func_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [N_BANK-1:0][WORD_W-1:0] bank_q;
  logic [1:0]                    sel_q;

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] q_r;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 2'(g))) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rd_en) q_r <= mem[rd_addr];
    end

    assign bank_q[g] = q_r;
  end

  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= rd_bank;
  end

  always_comb begin
    rd_word = '0;
    if (sel_q < 2'(N_BANK)) rd_word = bank_q[sel_q];
  end
endmodule

// File: rtl/pwl_madd.sv
module pwl_madd
  import pwl_func_pkg::*;
#(
  parameter int IN_W   = 21,
  parameter int ADDR_W = 10
) (
  input  logic [1:0]          fn,
  input  logic [WORD_W-1:0]   word,
  input  logic [IN_W-2-ADDR_W:0] y,
  output logic [RES_W-1:0]    result
);
  localparam int Y_W      = IN_W - 1 - ADDR_W;
  localparam int PRD_FRAC = B_FRAC + IN_W;
  localparam int M1       = (A_FRAC > PRD_FRAC) ? A_FRAC : PRD_FRAC;
  localparam int ACC_FRAC = (M1 > RES_W) ? M1 : RES_W;
  localparam int ACC_W    = ACC_FRAC + 2;
  localparam int SH_A     = ACC_FRAC - A_FRAC;
  localparam int SH_P     = ACC_FRAC - PRD_FRAC;
  localparam int SH_ONE   = ACC_FRAC - (RES_W - 1);
  localparam int SH_DBL   = ACC_FRAC - RES_W;

  logic [A_W-1:0]     a_mag;
  logic [B_W-1:0]     b_mag;
  logic [B_W+Y_W-1:0] prod;
  logic [ACC_W-1:0]   a_al, p_al, sum, shifted;
  logic               sub, dbl, under, sat;

  always_comb begin
    a_mag   = word[WORD_W-1 -: A_W];
    b_mag   = word[B_W-1:0];
    prod    = (B_W+Y_W)'(b_mag) * (B_W+Y_W)'(y);
    a_al    = ACC_W'(a_mag) << SH_A;
    p_al    = ACC_W'(prod) << SH_P;
    sub     = (fn != FN_SQRT);
    dbl     = (fn == FN_SQRT);
    under   = sub && (p_al > a_al);
    sum     = sub ? (a_al - p_al) : (a_al + p_al);
    sat     = dbl ? (|sum[ACC_W-1:ACC_FRAC]) : sum[ACC_W-1];
    shifted = dbl ? (sum >> SH_DBL) : (sum >> SH_ONE);
    if ((fn == FN_NONE) || under) result = '0;
    else if (sat)                 result = '1;
    else                          result = shifted[RES_W-1:0];
  end
endmodule

// File: rtl/pwl_func_unit.sv
module pwl_func_unit
  import pwl_func_pkg::*;
#(
  parameter int IN_W   = 21,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_func,
  input  logic [IN_W-1:0]   in_sig,
  input  logic              wr_en,
  input  logic [1:0]        wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [35:0]       wr_data,
  output logic              out_valid,
  output logic [23:0]       out_result
);
  localparam int Y_W = IN_W - 1 - ADDR_W;

  logic              v1_q, v1_d, v2_q, v2_d;
  logic [1:0]        fn1_q, fn1_d;
  logic [Y_W-1:0]    y1_q, y1_d;
  logic [RES_W-1:0]  res_q, res_d, res_calc;
  logic [WORD_W-1:0] coef_word;
  logic [ADDR_W-1:0] rd_addr;

  assign rd_addr = in_sig[IN_W-2 -: ADDR_W];

  pwl_coef_store #(.ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_bank(wr_bank),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (in_valid),
    .rd_bank(in_func),
    .rd_addr(rd_addr),
    .rd_word(coef_word)
  );

  pwl_madd #(.IN_W(IN_W), .ADDR_W(ADDR_W)) u_madd (
    .fn    (fn1_q),
    .word  (coef_word),
    .y     (y1_q),
    .result(res_calc)
  );

  always_comb begin
    v1_d  = in_valid;
    v2_d  = v1_q;
    fn1_d = in_valid ? in_func : fn1_q;
    y1_d  = in_valid ? in_sig[Y_W-1:0] : y1_q;
    res_d = v1_q ? res_calc : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  always_ff @(posedge clk) begin
    fn1_q <= fn1_d;
    y1_q  <= y1_d;
    res_q <= res_d;
  end

  assign out_valid  = v2_q;
  assign out_result = res_q;
endmodule

// File: rtl/pwl_func_unit_chk.sv
module pwl_func_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_func,
  input logic        out_valid,
  input logic [23:0] out_result
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= 2'd0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  // R1
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R1
  result_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_result));

  // R9
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q >= 2'd2) && out_valid && ($past(in_func, 2) == 2'b11)) |-> (out_result == 24'd0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q >= 2'd1) && !out_valid) |-> $stable(out_result));
endmodule

bind pwl_func_unit pwl_func_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_func   (in_func),
  .out_valid (out_valid),
  .out_result(out_result)
);

// File: tb/sim_pwl_func_unit.sv
`timescale 1ns/1ps
module sim_pwl_func_unit;
  localparam int IN_W = 9;
  localparam int AW   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_func;
  logic [IN_W-1:0] in_sig;
  logic        wr_en;
  logic [1:0]  wr_bank;
  logic [AW-1:0] wr_addr;
  logic [35:0] wr_data;
  logic        out_valid;
  logic [23:0] out_result;

  int checks = 0;
  int errors = 0;
  logic [22:0] ma [3][16];
  logic [12:0] mb [3][16];
  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        prev_in = 1'b0;
  logic [23:0] last_res;
  logic        mon_on = 1'b0;
  string       extra_tag = "";

  always #2.5 clk = ~clk;

  pwl_func_unit #(.IN_W(IN_W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_func(in_func),
    .in_sig(in_sig), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9: arithmetic model in units of 2^-24
  function automatic void model(input logic [1:0] fn, input logic [IN_W-1:0] x,
                                output logic [23:0] res, output string tag);
    int unsigned addr = x[7:4];
    int unsigned y    = x[3:0];
    longint a, p, n;
    res = 0;
    if (fn == 2'b11) begin tag = "R9"; return; end
    a = longint'(ma[fn][addr]) * 4;
    p = longint'(mb[fn][addr]) * y * 16;
    if (fn == 2'b01) begin
      n = a + p;
      if (n >= (64'd1 << 24)) begin res = 24'hFFFFFF; tag = "R8"; end
      else begin res = 24'(n); tag = "R5"; end
    end else begin
      if (p > a) begin res = 0; tag = "R7"; end
      else begin
        n = a - p;
        if (n >= (64'd1 << 25)) begin res = 24'hFFFFFF; tag = "R8"; end
        else begin res = 24'(n >> 1); tag = (fn == 2'b00) ? "R4" : "R6"; end
      end
    end
  endfunction

  // monitor, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      check("R1", {31'd0, out_valid}, {31'd0, prev_in});
      if (out_valid) begin
        if (exp_q.size() == 0) check("R1", 32'd1, 32'd0);
        else begin
          string t;
          logic [23:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {8'd0, out_result}, {8'd0, e});
        end
      end else begin
        check("R11", {8'd0, out_result}, {8'd0, last_res});
      end
      last_res = out_result;
      prev_in  = in_valid;
      if (in_valid) begin
        logic [23:0] r;
        string t;
        model(in_func, in_sig, r, t);
        exp_q.push_back(r);
        tag_q.push_back(extra_tag != "" ? extra_tag : t);
      end
    end
  end

  task automatic wr(input int bank, input int addr, input logic [22:0] a, input logic [12:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'(bank); wr_addr = AW'(addr); wr_data = {a, b};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input int fn, input int x, input bit v);
    @(negedge clk);
    in_valid = v; in_func = 2'(fn); in_sig = IN_W'(x);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_func = 2'b00; in_sig = '0;
    wr_en = 1'b0; wr_bank = 2'b00; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    // R3: tables packed as {a[22:0], b[12:0]}
    for (int bk = 0; bk < 3; bk++) begin
      for (int ad = 0; ad < 16; ad++) begin
        logic [22:0] a;
        logic [12:0] b;
        if (bk == 1) a = 23'((ad * 524287 + 3331) & 32'h7FFFFF);
        else         a = 23'h400000 | 23'((ad * 40961 + bk * 7777) & 32'h3FFFFF);
        b = 13'((ad * 331 + bk * 59 + 17) & 32'h1FFF);
        if (bk == 0 && ad == 0)  begin a = 23'h7FFFFF; b = 13'd0; end
        if (bk == 0 && ad == 1)  begin a = 23'd0;      b = 13'd1; end
        if (bk == 1 && ad == 15) begin a = 23'h3FFFFF; b = 13'h1FFF; end
        if (bk == 2 && ad == 15) begin a = 23'd5;      b = 13'h1FFF; end
        ma[bk][ad] = a; mb[bk][ad] = b;
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int bk = 0; bk < 3; bk++)
      for (int ad = 0; ad < 16; ad++) wr(bk, ad, ma[bk][ad], mb[bk][ad]);
    @(negedge clk);
    last_res = out_result;
    mon_on = 1'b1;
    // exhaustive sweep, every function code and every significand
    for (int fn = 0; fn < 4; fn++)
      for (int x = 256; x < 512; x++) issue(fn, x, 1'b1);
    // gaps in the valid stream
    for (int k = 0; k < 8; k++) issue(k % 4, 300 + k * 9, k[0]);
    issue(0, 256, 1'b0);
    repeat (4) issue(0, 256, 1'b0);
    // R10: bank 3 write ignored, other write local
    wr(3, 5, 23'h123456, 13'h0AB);
    wr(1, 2, 23'h2A0000, 13'h0155);
    ma[1][2] = 23'h2A0000; mb[1][2] = 13'h0155;
    extra_tag = "R10";
    for (int fn = 0; fn < 3; fn++) begin
      issue(fn, 256 + 5 * 16 + 7, 1'b1);
      issue(fn, 256 + 2 * 16 + 3, 1'b1);
    end
    issue(0, 256, 1'b0);
    repeat (5) @(negedge clk);
    check("R1", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule